// File: doc/BRIEF.md
# NAND page read pointer

This block is the device-side front end of a byte-wide NAND-style page memory, limited to page reads. A host writes command bytes with CLE high and address bytes with ALE high, each qualified by a one-clock write strobe. The block keeps a read pointer that selects one of three areas of a 528-byte page: the lower main half, the upper main half, or the 16-byte spare area. The column address is then placed inside that area.

When the row address of a read differs from the page already held, the block models the array-to-register transfer. It pulls the ready/busy output low for a fixed number of clocks. After that, each falling edge of the read-enable input returns the next byte. Output runs from the start column to the last column of the selected region. The pointer chosen by a command persists, so follow-on reads need only address cycles. The upper-half pointer is consumed by one read. The spare pointer stays until a lower-half command is issued.

The page contents come from a small computed read-only array. Programming, erase and status reads are not part of the block.

Top module: `nand_page_reader`

## Requirements
- R1: After reset rb_o is 1, data_o is 0 and the pointer is on the lower main half, so a read issued with no command starts at column A (the column byte).
- R2: Command 8'h00 selects the lower half, 8'h01 selects the upper half and 8'h50 selects the spare area. Any other command byte leaves the pointer unchanged.
- R3: A read takes four ALE writes: one column byte, then three row bytes, lowest first. The page index is the low PAGE_W bits of the first row byte.
- R4: The start column is A in the lower half and 256+A in the upper half. In the spare area it is 512 plus A[3:0], and A[7:4] is ignored.
- R5: After one read in the upper half, the pointer returns to the lower half for the next address-only read.
- R6: The spare pointer stays in force across reads. Command 8'h01 is ignored while it is set, and only 8'h00 leaves it.
- R7: A read whose 24-bit row differs from the held row, or the first read after reset, drives rb_o low for exactly BUSY_CYC clocks, starting one clock after the last address write.
- R8: A read of the row already held leaves rb_o high and takes its new start column at once.
- R9: Each falling edge of re_i outputs the byte at the current column and then advances the column. The byte equals (col mod 256) XOR (64*(col div 256) + page).
- R10: The last column is 511 for both main halves and 527 for the spare area. Further falling edges repeat the last byte, and the column does not wrap.
- R11: A latched command stays in force, so a read made only of address writes uses the current pointer.
- R12: While rb_o is low, command writes, address writes and re_i edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | One-clock write strobe for command or address byte |
| cle_i | input | 1 | Qualifies a write as a command byte |
| ale_i | input | 1 | Qualifies a write as an address byte |
| re_i | input | 1 | Read enable, a byte is returned on each high-to-low edge |
| data_i | input | 8 | Command or address byte |
| data_o | output | 8 | Page byte out |
| rb_o | output | 1 | Ready (1) or busy (0) |

## Verification
The bench targets pointer transitions. If the upper-half pointer were made sticky, an address-only read after it would start 256 columns high. If a stray 8'h01 could leave the spare area, the spare read would return main-area data. Several runs push read-enable past the end of a region: a column counter that wraps or crosses from main into spare shows up as a wrong byte. The bench also times the busy window, checks that a same-row read skips the busy window, and checks that a command and an RE edge sent during the busy window do not move the pointer or the output.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
  typedef enum logic [1:0] {
    AREA_LO = 2'd0,
    AREA_HI = 2'd1,
    AREA_SP = 2'd2
  } area_e;

  localparam int unsigned COL_W     = 10;
  localparam int unsigned ADDR_CYC  = 4;
  localparam int unsigned ROW_W     = 8 * (ADDR_CYC - 1);
  localparam logic [7:0]  CMD_LO    = 8'h00;
  localparam logic [7:0]  CMD_HI    = 8'h01;
  localparam logic [7:0]  CMD_SP    = 8'h50;
  localparam logic [COL_W-1:0] MAIN_LAST = 10'd511;
  localparam logic [COL_W-1:0] PAGE_LAST = 10'd527;
endpackage

// File: rtl/nand_cmd_dec.sv
module nand_cmd_dec
  import nand_rd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             cle_i,
  input  logic             ale_i,
  input  logic [7:0]       din_i,
  input  logic             busy_i,
  output logic             done_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] start_col_o,
  output logic [COL_W-1:0] end_col_o,
  output area_e            area_o,
  output area_e            mode_o
);
  localparam int unsigned IDX_W = $clog2(ADDR_CYC);

  logic             cmd_we, addr_we;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       col_q;
  logic [ROW_W-1:0] row_acc_q, row_nx;
  logic [COL_W-1:0] start_nx, end_nx;
  area_e            mode_q;

  assign cmd_we  = we_i & cle_i & ~ale_i & ~busy_i;
  assign addr_we = we_i & ale_i & ~cle_i & ~busy_i;
  assign row_nx  = {din_i, row_acc_q[ROW_W-1:8]};
  assign mode_o  = mode_q;

  always_comb begin
    unique case (mode_q)
      AREA_HI: begin start_nx = {2'b01, col_q};             end_nx = MAIN_LAST; end
      AREA_SP: begin start_nx = {2'b10, 4'b0, col_q[3:0]};  end_nx = PAGE_LAST; end
      default: begin start_nx = {2'b00, col_q};             end_nx = MAIN_LAST; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= AREA_LO;
      idx_q       <= '0;
      col_q       <= '0;
      row_acc_q   <= '0;
      done_o      <= 1'b0;
      row_o       <= '0;
      start_col_o <= '0;
      end_col_o   <= MAIN_LAST;
      area_o      <= AREA_LO;
    end else begin
      done_o <= 1'b0;
      if (cmd_we) begin
        idx_q <= '0;
        if (din_i == CMD_LO)
          mode_q <= AREA_LO;
        else if (din_i == CMD_HI && mode_q != AREA_SP)
          mode_q <= AREA_HI;
        else if (din_i == CMD_SP)
          mode_q <= AREA_SP;
      end else if (addr_we) begin
        if (idx_q == '0) col_q <= din_i;
        else             row_acc_q <= row_nx;
        if (idx_q == IDX_W'(ADDR_CYC - 1)) begin
          idx_q       <= '0;
          done_o      <= 1'b1;
          row_o       <= row_nx;
          start_col_o <= start_nx;
          end_col_o   <= end_nx;
          area_o      <= mode_q;
          if (mode_q == AREA_HI) mode_q <= AREA_LO;  // upper half is one-shot
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int unsigned BUSY_CYC = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= CNT_W'(BUSY_CYC);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/nand_col_ctr.sv
module nand_col_ctr
  import nand_rd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [COL_W-1:0] start_i,
  input  logic [COL_W-1:0] end_i,
  input  logic             step_i,
  output logic [COL_W-1:0] col_o,
  output logic [COL_W-1:0] end_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_o <= '0;
      end_o <= MAIN_LAST;
    end else if (load_i) begin
      col_o <= start_i;
      end_o <= end_i;
    end else if (step_i && col_o != end_o) begin
      col_o <= col_o + 1'b1;
    end
  end
endmodule

// File: rtl/nand_page_rom.sv
module nand_page_rom
  import nand_rd_pkg::*;
#(
  parameter int unsigned PAGE_W = 2
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [7:0]        data_o
);
  logic [5:0] pg6;

  assign pg6    = 6'(page_i);
  assign data_o = col_i[7:0] ^ {col_i[9:8], pg6};
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nand_rd_pkg::*;
#(
  parameter int unsigned BUSY_CYC = 6,
  parameter int unsigned PAGE_W   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       re_i,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  output logic       rb_o
);
  logic             busy, done, xfer, step, re_q, re_fall;
  logic             loaded_vld_q, rd_vld_q;
  logic [ROW_W-1:0] row, loaded_row_q;
  logic [COL_W-1:0] start_col, end_col, cur_col, cur_end;
  logic [7:0]       rom_byte;
  area_e            area, mode;

  nand_cmd_dec u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .cle_i(cle_i), .ale_i(ale_i),
    .din_i(data_i), .busy_i(busy), .done_o(done), .row_o(row),
    .start_col_o(start_col), .end_col_o(end_col), .area_o(area), .mode_o(mode)
  );

  nand_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(xfer), .busy_o(busy)
  );

  nand_col_ctr u_col (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(done), .start_i(start_col),
    .end_i(end_col), .step_i(step), .col_o(cur_col), .end_o(cur_end)
  );

  nand_page_rom #(.PAGE_W(PAGE_W)) u_rom (
    .page_i(loaded_row_q[PAGE_W-1:0]), .col_i(cur_col), .data_o(rom_byte)
  );

  assign re_fall = re_q & ~re_i;
  assign xfer    = done & (~loaded_vld_q | (row != loaded_row_q));
  assign step    = re_fall & ~busy & rd_vld_q & ~done;
  assign rb_o    = ~busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_q         <= 1'b1;
      loaded_vld_q <= 1'b0;
      rd_vld_q     <= 1'b0;
      loaded_row_q <= '0;
      data_o       <= '0;
    end else begin
      re_q <= re_i;
      if (done) begin
        loaded_row_q <= row;
        loaded_vld_q <= 1'b1;
        rd_vld_q     <= 1'b1;
      end
      if (step) data_o <= rom_byte;
    end
  end
endmodule

// File: rtl/nand_page_reader_chk.sv
module nand_page_reader_chk
  import nand_rd_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic             cle_i,
  input logic [7:0]       data_i,
  input logic [7:0]       data_o,
  input logic             rb_o,
  input logic             done,
  input logic             step,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] cur_col,
  input logic [COL_W-1:0] cur_end,
  input area_e            area,
  input area_e            mode
);
  AST_SPARE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == AREA_SP && !(we_i && cle_i && data_i == CMD_LO)) |=> mode == AREA_SP); // R6

  AST_HI_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && area == AREA_HI) |-> mode != AREA_HI); // R5

  AST_SPARE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && area == AREA_SP) |-> start_col[9:4] == 6'h20); // R4

  AST_BUSY_AFTER_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rb_o) |-> $past(done)); // R7

  AST_BUSY_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rb_o) |-> $stable(data_o)); // R12

  AST_END_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && cur_col == cur_end) |=> $stable(cur_col)); // R10
endmodule

bind nand_page_reader nand_page_reader_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .cle_i(cle_i), .data_i(data_i),
  .data_o(data_o), .rb_o(rb_o), .done(done), .step(step), .start_col(start_col),
  .cur_col(cur_col), .cur_end(cur_end), .area(area), .mode(mode)
);

// File: tb/sim_nand_page_reader.sv
module sim_nand_page_reader;
  localparam int BUSY = 6;

  typedef struct packed {
    logic       has_cmd;
    logic [7:0] cmd;
    logic [7:0] col;
    logic [7:0] page;
    logic [4:0] nreads;
    logic       exp_busy;
    logic [9:0] exp_start;
    logic [9:0] exp_end;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{1'b1, 8'h00, 8'h05, 8'd1, 5'd3,  1'b1, 10'd5,   10'd511}, // R2 R7 new page
    '{1'b1, 8'h01, 8'h0A, 8'd1, 5'd3,  1'b0, 10'd266, 10'd511}, // R4 R8 upper half
    '{1'b0, 8'h00, 8'h07, 8'd1, 5'd2,  1'b0, 10'd7,   10'd511}, // R5 back to lower
    '{1'b1, 8'h50, 8'hF3, 8'd2, 5'd14, 1'b1, 10'd515, 10'd527}, // R4 R10 spare end hold
    '{1'b0, 8'h00, 8'h0E, 8'd2, 5'd3,  1'b0, 10'd526, 10'd527}, // R6 R11 spare sticky
    '{1'b1, 8'h01, 8'h01, 8'd3, 5'd2,  1'b1, 10'd513, 10'd527}, // R6 01h ignored in spare
    '{1'b1, 8'h00, 8'hFE, 8'd3, 5'd3,  1'b0, 10'd254, 10'd511}, // R2 R8 leave spare
    '{1'b1, 8'h01, 8'hFE, 8'd0, 5'd4,  1'b1, 10'd510, 10'd511}, // R10 main end hold
    '{1'b0, 8'h00, 8'h00, 8'd0, 5'd2,  1'b0, 10'd0,   10'd511}  // R5 R11
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0, cle = 1'b0, ale = 1'b0, re = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       rb;
  int         total = 0, bad = 0;

  always #2 clk = ~clk;

  nand_page_reader #(.BUSY_CYC(BUSY), .PAGE_W(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .cle_i(cle), .ale_i(ale),
    .re_i(re), .data_i(din), .data_o(dout), .rb_o(rb)
  );

  function automatic logic [7:0] exp_byte(input logic [7:0] pg, input logic [9:0] c);
    return c[7:0] ^ {c[9:8], pg[5:0]};
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk);
    cle = c; ale = a; din = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; cle = 1'b0; ale = 1'b0;
  endtask

  task automatic addr(input logic [7:0] c, input logic [7:0] r1, input logic [7:0] r2);
    wr(1'b0, 1'b1, c);
    wr(1'b0, 1'b1, r1);
    wr(1'b0, 1'b1, r2);
    wr(1'b0, 1'b1, 8'h00);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    for (int i = 0; i < BUSY + 6; i++) begin
      @(negedge clk);
      if (!rb) n++;
    end
  endtask

  task automatic re_pulse(output logic [7:0] q);
    @(negedge clk);
    re = 1'b0;
    @(negedge clk);
    q = dout;
    re = 1'b1;
  endtask

  task automatic read_run(input string tag, input logic [7:0] pg, input int st,
                          input int en, input int n);
    logic [7:0] q;
    for (int k = 0; k < n; k++) begin
      int c;
      c = (st + k > en) ? en : st + k;
      re_pulse(q);
      chk(tag, q, exp_byte(pg, 10'(c)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] q, held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rb", rb, 1);
    chk("R1 data", dout, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rb after release", rb, 1);

    // R1 R7: no command, first read loads page 0 from lower half
    addr(8'h03, 8'h00, 8'h00);
    busy_len(n);
    chk("R7 first load busy", n, BUSY);
    read_run("R1 default lower", 8'd0, 3, 511, 2);

    for (int i = 0; i < 9; i++) begin
      vec_t v;
      v = TBL[i];
      if (v.has_cmd) wr(1'b1, 1'b0, v.cmd);
      addr(v.col, v.page, 8'h00);
      busy_len(n);
      chk(v.exp_busy ? "R7 busy len" : "R8 no busy", n, v.exp_busy ? BUSY : 0);
      read_run("R9 R10 data", v.page, int'(v.exp_start), int'(v.exp_end), int'(v.nreads));
    end

    // R2: unknown command leaves upper-half pointer in place
    wr(1'b1, 1'b0, 8'h01);
    wr(1'b1, 1'b0, 8'hA5);
    addr(8'h04, 8'h00, 8'h00);
    busy_len(n);
    chk("R2 same page no busy", n, 0);
    read_run("R2 unknown cmd ignored", 8'd0, 260, 511, 1);

    // R12: command and RE during busy are ignored
    held = dout;
    addr(8'h09, 8'h02, 8'h00);
    wr(1'b1, 1'b0, 8'h50);
    re_pulse(q);
    chk("R12 data frozen in busy", q, held);
    busy_len(n);
    chk("R12 rb back high", rb, 1);
    read_run("R12 RE in busy no advance", 8'd2, 9, 511, 1);
    addr(8'h20, 8'h02, 8'h00);
    busy_len(n);
    chk("R12 busy-time cmd dropped no busy", n, 0);
    read_run("R12 pointer still lower", 8'd2, 32, 511, 1);

    // R3: upper row byte changes row, page still from first row byte
    addr(8'h01, 8'h02, 8'h07);
    busy_len(n);
    chk("R3 row change busy", n, BUSY);
    read_run("R3 page from first row byte", 8'd2, 1, 511, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule